// File: doc/BRIEF.md
# Serial FPGA Configuration Master

This block loads a configuration bitstream into an FPGA whose configuration port is in serial-slave mode. It takes bytes from a valid/ready stream and runs the whole programming sequence on its own. First it pulses the program request and waits for the target to signal that it is initialising. Then it releases the program request and waits for that signal to clear. After that it shifts every byte out on a single data line, most significant bit first, with a divided configuration clock. After the final byte it keeps clocking with the data line held high until the target reports that configuration is complete.

Every wait phase has a cycle-count timeout. Before each byte the block checks whether the target has flagged a CRC error, which shows as the init line going active while the done line is still low. Failures in the handshake phases raise a one-cycle abort strobe. One-cycle strobes also mark the start of a load and the end of the completion phase, so that surrounding logic can prepare or tidy up the board. All pin polarities are abstracted: every flag at the boundary of the block is active high.

Top module: `serial_cfg_master`

## Requirements
- R1: A `start` pulse while idle gives exactly one cycle of `pre_strobe`. `prog_active` then stays high until `init_active` is seen high. A `start` pulse while `busy` is high has no effect.
- R2: After `prog_active` falls, `byte_ready` stays low and `cclk` stays low for as long as `init_active` remains high.
- R3: Each accepted byte produces exactly 8 rising edges of `cclk`, carrying bit 7 first and bit 0 last. Each low phase and each high phase of `cclk` lasts `HALF_CYC` system clock cycles.
- R4: `din` changes only while `cclk` is low, and it is stable for the whole time `cclk` is high.
- R5: When the block is ready for a byte and `init_active` is high while `done_in` is low, it returns to idle. It sets `crc_error` and `fail`, pulses `abort` for one cycle, and issues no `post_strobe`.
- R6: After the byte flagged `byte_last` has been shifted, `din` is held at 1 and `cclk` keeps toggling with the same half-period until `done_in` is sampled high. The block then sets `done_ok`.
- R7: Each wait phase lasts at most `TIMEOUT_CYC` cycles: waiting for init to go active, waiting for init to clear, and waiting for done. A timeout in either init phase sets `fail` and pulses `abort`. A timeout in the done phase sets `fail` with no `abort`.
- R8: `post_strobe` pulses for one cycle when the done phase ends, whether it ends in success or in timeout. `done_ok` rises in that same cycle.
- R9: `busy` is high from the cycle after an accepted `start` until the block is idle again. `done_ok`, `fail` and `crc_error` hold their values until the next accepted `start`, which clears them.
- R10: After reset the block is idle. All outputs are low except `din`, which is 1.
- R11: `byte_ready` is high only while the block is waiting for a byte. While no byte is offered, `cclk` stays low and no bit is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (pulse, honoured only when idle) |
| byte_data | input | 8 | Bitstream byte |
| byte_valid | input | 1 | Byte offered |
| byte_last | input | 1 | Offered byte is the final one |
| byte_ready | output | 1 | Byte taken when high together with byte_valid |
| init_active | input | 1 | Target init line, active level |
| done_in | input | 1 | Target done line, high when configured |
| prog_active | output | 1 | Program request to the target |
| cclk | output | 1 | Configuration clock |
| din | output | 1 | Configuration serial data |
| pre_strobe | output | 1 | One-cycle strobe before the program request |
| post_strobe | output | 1 | One-cycle strobe when the done phase ends |
| abort | output | 1 | One-cycle strobe on a handshake or CRC failure |
| busy | output | 1 | Load in progress |
| done_ok | output | 1 | Last load finished with done seen |
| fail | output | 1 | Last load failed |
| crc_error | output | 1 | Last load stopped on a CRC error |

## Verification
A corrupted shift register or bit counter shows up as a wrong `din` value or an extra or missing `cclk` rising edge within one byte time, about 16·`HALF_CYC` cycles. A phase register that is wrong shows up as a `prog_active`, `byte_ready` or `cclk` value that differs from the expected one in the very next cycle. A timeout counter that is off shows up as `fail`, `abort` or `post_strobe` arriving one or more cycles early or late at the end of a wait phase. The bench compares every output against its own model on every cycle. It also rebuilds each byte from the `din` values sampled on the rising edges of `cclk`.

// File: rtl/serial_cfg_master.sv
module serial_cfg_master #(
  parameter int HALF_CYC    = 4,
  parameter int TIMEOUT_CYC = 1250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] byte_data,
  input  logic       byte_valid,
  input  logic       byte_last,
  output logic       byte_ready,
  input  logic       init_active,
  input  logic       done_in,
  output logic       prog_active,
  output logic       cclk,
  output logic       din,
  output logic       pre_strobe,
  output logic       post_strobe,
  output logic       abort,
  output logic       busy,
  output logic       done_ok,
  output logic       fail,
  output logic       crc_error
);
  localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_PROG, S_WCLR, S_FETCH, S_LO, S_HI, S_FLO, S_FHI, S_POST
  } state_t;

  state_t        state;
  logic [TW-1:0] tmr;
  logic [DW-1:0] div;
  logic [7:0]    sh;
  logic [2:0]    nbit;
  logic          lastq;

  wire crc_hit = init_active && !done_in;
  wire tmr_end = (tmr == TW'(TIMEOUT_CYC - 1));
  wire div_end = (div == DW'(HALF_CYC - 1));

  assign pre_strobe  = (state == S_PRE);
  assign prog_active = (state == S_PROG);
  assign post_strobe = (state == S_POST);
  assign busy        = (state != S_IDLE);
  assign cclk        = (state == S_HI) || (state == S_FHI);
  assign din         = (state == S_LO || state == S_HI) ? sh[7] : 1'b1;
  assign byte_ready  = (state == S_FETCH) && !crc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; tmr <= '0; div <= '0; sh <= '0; nbit <= '0; lastq <= 1'b0;
      abort <= 1'b0; done_ok <= 1'b0; fail <= 1'b0; crc_error <= 1'b0;
    end else begin
      abort <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_PRE; done_ok <= 1'b0; fail <= 1'b0; crc_error <= 1'b0;
        end
        S_PRE: begin state <= S_PROG; tmr <= '0; end
        S_PROG:
          if (init_active) begin state <= S_WCLR; tmr <= '0; end
          else if (tmr_end) begin fail <= 1'b1; abort <= 1'b1; state <= S_IDLE; end
          else tmr <= tmr + 1'b1;
        S_WCLR:
          if (!init_active) state <= S_FETCH;
          else if (tmr_end) begin fail <= 1'b1; abort <= 1'b1; state <= S_IDLE; end
          else tmr <= tmr + 1'b1;
        S_FETCH:
          if (crc_hit) begin
            crc_error <= 1'b1; fail <= 1'b1; abort <= 1'b1; state <= S_IDLE;
          end else if (byte_valid) begin
            sh <= byte_data; lastq <= byte_last; nbit <= '0; div <= '0; state <= S_LO;
          end
        S_LO:
          if (div_end) begin div <= '0; state <= S_HI; end
          else div <= div + 1'b1;
        S_HI:
          if (div_end) begin
            div <= '0;
            if (nbit == 3'd7) begin
              if (lastq) begin state <= S_FLO; tmr <= '0; end
              else state <= S_FETCH;
            end else begin
              sh <= {sh[6:0], 1'b0}; nbit <= nbit + 1'b1; state <= S_LO;
            end
          end else div <= div + 1'b1;
        S_FLO, S_FHI:
          if (done_in) begin done_ok <= 1'b1; state <= S_POST; end
          else if (tmr_end) begin fail <= 1'b1; state <= S_POST; end
          else begin
            tmr <= tmr + 1'b1;
            if (div_end) begin
              div <= '0;
              state <= (state == S_FLO) ? S_FHI : S_FLO;
            end else div <= div + 1'b1;
          end
        S_POST: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_PROG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_active |-> busy); // R1
  AST_NO_READY_ON_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> !(init_active && !done_in)); // R5
  AST_DIN_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk && $past(cclk)) |-> $stable(din)); // R4
  AST_OK_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && fail)); // R7
  AST_OK_WITH_POST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_ok) |-> post_strobe); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pre_strobe, post_strobe, abort}) <= 1); // R9
endmodule

// File: tb/tb_serial_cfg_master.sv
module tb_serial_cfg_master;
  localparam int HC = 2;
  localparam int TO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, byte_valid = 1'b0, byte_last = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic init_active = 1'b0, done_in = 1'b0;
  logic byte_ready, prog_active, cclk, din, pre_strobe, post_strobe, abort;
  logic busy, done_ok, fail, crc_error;

  always #4 clk = ~clk;

  serial_cfg_master #(.HALF_CYC(HC), .TIMEOUT_CYC(TO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_data(byte_data),
    .byte_valid(byte_valid), .byte_last(byte_last), .byte_ready(byte_ready),
    .init_active(init_active), .done_in(done_in), .prog_active(prog_active),
    .cclk(cclk), .din(din), .pre_strobe(pre_strobe), .post_strobe(post_strobe),
    .abort(abort), .busy(busy), .done_ok(done_ok), .fail(fail), .crc_error(crc_error));

  int vectors = 0, miscompares = 0, cyc = 0;
  bit finished = 0;

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: phase codes, down-counting waits
  localparam int P_IDLE = 0, P_PRE = 1, P_PROG = 2, P_CLR = 3, P_GET = 4,
                 P_LO = 5, P_HI = 6, P_FLO = 7, P_FHI = 8, P_POST = 9;
  int m_ph = P_IDLE, m_left = 0, m_h = 0, m_bits = 0, m_val = 0;
  bit m_lst = 0, m_abort = 0, m_ok = 0, m_fail = 0, m_crc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = P_IDLE; m_abort = 0; m_ok = 0; m_fail = 0; m_crc = 0;
    end else begin
      m_abort = 0;
      if (m_ph == P_IDLE) begin
        if (start) begin m_ph = P_PRE; m_ok = 0; m_fail = 0; m_crc = 0; end
      end else if (m_ph == P_PRE) begin
        m_ph = P_PROG; m_left = TO - 1;
      end else if (m_ph == P_PROG || m_ph == P_CLR) begin
        if ((m_ph == P_PROG) == init_active) begin
          m_ph = (m_ph == P_PROG) ? P_CLR : P_GET; m_left = TO - 1;
        end else if (m_left == 0) begin
          m_fail = 1; m_abort = 1; m_ph = P_IDLE;
        end else m_left--;
      end else if (m_ph == P_GET) begin
        if (init_active && !done_in) begin
          m_crc = 1; m_fail = 1; m_abort = 1; m_ph = P_IDLE;
        end else if (byte_valid) begin
          m_val = byte_data; m_lst = byte_last; m_bits = 8; m_h = HC - 1; m_ph = P_LO;
        end
      end else if (m_ph == P_LO) begin
        if (m_h == 0) begin m_h = HC - 1; m_ph = P_HI; end else m_h--;
      end else if (m_ph == P_HI) begin
        if (m_h == 0) begin
          m_h = HC - 1; m_bits--;
          if (m_bits == 0) begin
            if (m_lst) begin m_ph = P_FLO; m_left = TO - 1; end else m_ph = P_GET;
          end else begin m_val = (m_val << 1) & 255; m_ph = P_LO; end
        end else m_h--;
      end else if (m_ph == P_FLO || m_ph == P_FHI) begin
        if (done_in) begin m_ok = 1; m_ph = P_POST; end
        else if (m_left == 0) begin m_fail = 1; m_ph = P_POST; end
        else begin
          m_left--;
          if (m_h == 0) begin m_h = HC - 1; m_ph = (m_ph == P_FLO) ? P_FHI : P_FLO; end
          else m_h--;
        end
      end else m_ph = P_IDLE;
    end
  end

  always begin
    @(negedge clk); #3;
    if (rst_n && !finished) begin
      check("R1 prog_active", prog_active, m_ph == P_PROG);
      check("R1 pre_strobe", pre_strobe, m_ph == P_PRE);
      check("R11 byte_ready", byte_ready, (m_ph == P_GET) && !(init_active && !done_in));
      check("R3 cclk", cclk, (m_ph == P_HI) || (m_ph == P_FHI));
      check("R4 din", din, (m_ph == P_LO || m_ph == P_HI) ? ((m_val >> 7) & 1) : 1);
      check("R5 abort", abort, m_abort);
      check("R5 crc_error", crc_error, m_crc);
      check("R6 done_ok", done_ok, m_ok);
      check("R7 fail", fail, m_fail);
      check("R8 post_strobe", post_strobe, m_ph == P_POST);
      check("R9 busy", busy, m_ph != P_IDLE);
    end
  end

  bit cap[$];
  int sent[$];
  always @(posedge cclk) cap.push_back(din);

  task automatic tick; @(negedge clk); #1; endtask
  task automatic pulse_start; tick; start = 1; tick; start = 0; endtask
  task automatic wait_idle; while (busy) tick; endtask

  task automatic handshake;
    cap.delete(); sent.delete();
    pulse_start;
    while (!prog_active) tick;
    repeat (3) tick;
    init_active = 1;
    while (prog_active) tick;
    repeat (2) tick;
    check("R2 no ready while init", byte_ready, 0);
    check("R2 cclk idle while init", cclk, 0);
    init_active = 0;
  endtask

  task automatic send_byte(int d, bit l);
    byte_data = d[7:0]; byte_valid = 1; byte_last = l;
    while (!byte_ready) tick;
    tick;
    byte_valid = 0; byte_last = 0;
    sent.push_back(d);
  endtask

  task automatic check_bits;
    foreach (sent[i]) begin
      int got = 0;
      for (int b = 0; b < 8; b++)
        got = (got << 1) | ((i * 8 + b < cap.size()) ? int'(cap[i * 8 + b]) : 0);
      check("R3 byte msb first", got, sent[i]);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1; miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    check("R10 busy", busy, 0); check("R10 cclk", cclk, 0); check("R10 din", din, 1);
    check("R10 prog", prog_active, 0); check("R10 fail", fail, 0);
    rst_n = 1;
    repeat (2) tick;

    // normal load, stall between bytes, start while busy ignored
    handshake;
    send_byte(8'hA5, 0);
    start = 1; tick; start = 0;
    check("R1 start ignored busy", busy, 1);
    repeat (40) tick;
    check("R11 cclk low while stalled", cclk, 0);
    send_byte(8'h3C, 0);
    send_byte(8'h81, 1);
    repeat (12) tick;
    done_in = 1;
    wait_idle;
    check("R6 done_ok", done_ok, 1);
    check("R7 no fail", fail, 0);
    check_bits;
    done_in = 0; repeat (3) tick;

    // init never active
    pulse_start; tick; wait_idle; tick;
    check("R7 fail init-active timeout", fail, 1);
    check("R5 no crc on timeout", crc_error, 0);

    // init never clears
    pulse_start;
    while (!prog_active) tick;
    init_active = 1; tick; wait_idle; tick;
    check("R7 fail init-clear timeout", fail, 1);
    init_active = 0; repeat (3) tick;

    // crc error between bytes
    handshake;
    send_byte(8'h5A, 0);
    init_active = 1;
    wait_idle; tick;
    check("R5 crc_error", crc_error, 1);
    check("R5 fail", fail, 1);
    check_bits;
    init_active = 0; repeat (3) tick;

    // done never arrives
    handshake;
    send_byte(8'hFF, 1);
    wait_idle; tick;
    check("R7 fail done timeout", fail, 1);
    check("R8 no done_ok", done_ok, 0);
    check_bits;

    // flags cleared by start, done already high at flush
    handshake;
    check("R9 fail cleared", fail, 0);
    done_in = 1;
    send_byte(8'h01, 0);
    send_byte(8'hC3, 1);
    wait_idle; tick;
    check("R6 done_ok immediate", done_ok, 1);
    check_bits;
    done_in = 0;
    repeat (5) tick;
    check("R9 done_ok held", done_ok, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule